// File: doc/BRIEF.md
# MMU and Exception State Register Block

This block holds the software-visible state that a processor core uses for address translation and exception handling. It contains nine 32-bit registers on a small word-addressed register bus: the MMU control word, the high, low and assist words of a page-table entry, the translation table base, the faulting exception address, and three event-code registers (trap code, exception event, interrupt event). Some registers keep only part of the written data, so software cannot set bits that have no meaning.

Two writes have side effects that go to the TLB logic outside the block. A write to the control word with its invalidate bit set raises a one-cycle invalidate pulse, and that bit is never stored. A write to the page-table-entry high word raises a one-cycle flush pulse, but only when the low address-space-identifier field changes. Each request is answered one cycle later with a response strobe, an error flag and the read data. An access to an undecoded address, or at a width other than 32 bits, gets an error response and changes nothing.

Top module: `mmu_exc_regs`

## Requirements
- R1: After reset every register reads 0, and neither pulse is asserted.
- R2: An accepted 32-bit write to the control word (offset 0x00) with bit 2 set drives `tlb_inval` high for exactly one cycle, in the same cycle as that write's response. A write with bit 2 clear gives no pulse.
- R3: Bit 2 of the control word is never stored and always reads 0. Every other bit stores the written value.
- R4: An accepted 32-bit write to the entry-high word (offset 0x04) whose bits [7:0] (the address-space identifier) differ from the stored bits [7:0] drives `tlb_flush` high for one cycle, in the response cycle of that write.
- R5: An entry-high write that leaves bits [7:0] unchanged gives no flush pulse, and its upper bits are still stored.
- R6: The trap code (0x18), exception event (0x1C) and interrupt event (0x20) registers keep only bits [10:0] of a write. The upper bits read 0.
- R7: The entry-assist word (0x0C) keeps only bits [3:0] of a write.
- R8: The entry-low (0x08), table-base (0x10) and exception-address (0x14) registers store all 32 bits.
- R9: An access at an offset that is not word aligned, or above 0x20, gets `rsp_err`=1 and read data 0, and changes no register.
- R10: An access whose `req_size` is not 2 (0 byte, 1 halfword, 2 word, 3 reserved) gets `rsp_err`=1, changes no register, and raises no pulse.
- R11: Every request cycle is answered in the next cycle with `rsp_valid`=1. A legal read returns the register's value in `rsp_rdata`. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access width code: 0 byte, 1 half, 2 word, 3 reserved |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | The request was rejected |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| tlb_inval | output | 1 | One-cycle invalidate-all pulse |
| tlb_flush | output | 1 | One-cycle flush pulse on an identifier change |

## Verification
The hardest case is a flush decision that depends on history: whether an entry-high write pulses depends on what the identifier field already holds, not on the write itself. The stimulus first loads a known identifier, then writes the same identifier with different upper bits and expects no pulse, then changes only the identifier and expects a pulse. It also sends a narrow-width write that carries a new identifier, to show that a rejected access neither pulses nor updates the comparison state.

// File: rtl/mxr_pkg.sv
// Package: shared constants for the MMU/exception register block.
// Assumes a word-spaced register map starting at offset 0.
package mxr_pkg;
    localparam int NREG  = 9;
    localparam int IDX_W = $clog2(NREG);

    // Register word indices (byte offset = index * 4)
    localparam int IDX_CTRL  = 0;
    localparam int IDX_PTEH  = 1;
    localparam int IDX_PTEL  = 2;
    localparam int IDX_PTEA  = 3;
    localparam int IDX_TBASE = 4;
    localparam int IDX_EXCA  = 5;
    localparam int IDX_TRAP  = 6;
    localparam int IDX_EXPEV = 7;
    localparam int IDX_INTEV = 8;

    // Access width codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/mxr_decode.sv
// Module: address/width decoder.
// Maps a byte offset to a register index and reports whether the offset is
// word aligned and inside the map. Purely combinational.
module mxr_decode
    import mxr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output logic              size_ok,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    // Split the offset into word index and byte lane, then range-check
    always_comb begin
        word    = addr[ADDR_W-1:2];
        hit     = (addr[1:0] == 2'b00) && (int'(word) < NREG);
        size_ok = (size == SZ_WORD);
        idx     = word[IDX_W-1:0];
    end
endmodule

// File: rtl/mxr_bank.sv
// Module: register bank.
// Holds the nine registers; each keeps only its legal bits on write.
// Assumes wr_en is asserted only for a legal, decoded 32-bit write.
module mxr_bank
    import mxr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ASID_W   = 8,
    parameter int EVT_W    = 11,
    parameter int ASSIST_W = 4,
    parameter int INV_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [ASID_W-1:0] asid_q
);
    // Bits each register keeps on write
    function automatic logic [DATA_W-1:0] keep_for(int i);
        logic [DATA_W-1:0] m;
        m = '1;
        case (i)
            IDX_CTRL:  m[INV_BIT] = 1'b0;
            IDX_PTEA:  m = (DATA_W'(1) << ASSIST_W) - DATA_W'(1);
            IDX_TRAP,
            IDX_EXPEV,
            IDX_INTEV: m = (DATA_W'(1) << EVT_W) - DATA_W'(1);
            default:   m = '1;
        endcase
        return m;
    endfunction

    logic [DATA_W-1:0] q_vec [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP = keep_for(g);
        logic [DATA_W-1:0] q;

        // Store the masked write data when this register is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                q <= wdata & KEEP;
            end
        end

        assign q_vec[g] = q;
    end

    // Read multiplexer; unknown indices read as zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) rd_data = q_vec[i];
        end
    end

    assign asid_q = q_vec[IDX_PTEH][ASID_W-1:0];
endmodule

// File: rtl/mxr_resp.sv
// Module: response and side-effect pulse stage.
// Registers the bus response and the two TLB pulses, so each appears in the
// cycle after the request. Assumes the requests arrive at most one per cycle.
module mxr_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              legal,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              inval_req,
    input  logic              flush_req,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tlb_inval,
    output logic              tlb_flush
);
    // Capture response fields and one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            tlb_inval <= 1'b0;
            tlb_flush <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && !req_write && legal) ? rd_data : '0;
            tlb_inval <= inval_req;
            tlb_flush <= flush_req;
        end
    end
endmodule

// File: rtl/mmu_exc_regs.sv
// Module: top of the MMU/exception register block.
// Decodes 32-bit register-bus requests, updates the register bank and
// produces TLB invalidate/flush pulses. Assumes one request per cycle and a
// synchronous active-low reset.
module mmu_exc_regs
    import mxr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ASID_W   = 8,
    parameter int EVT_W    = 11,
    parameter int ASSIST_W = 4,
    parameter int INV_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tlb_inval,
    output logic              tlb_flush
);
    logic              hit;
    logic              size_ok;
    logic [IDX_W-1:0]  idx;
    logic              legal;
    logic              wr_ok;
    logic [DATA_W-1:0] rd_data;
    logic [ASID_W-1:0] asid_q;
    logic              inval_req;
    logic              flush_req;

    mxr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (req_addr),
        .size    (req_size),
        .hit     (hit),
        .size_ok (size_ok),
        .idx     (idx)
    );

    // Qualify the request and derive the side-effect requests
    always_comb begin
        legal     = hit && size_ok;
        wr_ok     = req_valid && req_write && legal;
        inval_req = wr_ok && (idx == IDX_W'(IDX_CTRL)) && req_wdata[INV_BIT];
        flush_req = wr_ok && (idx == IDX_W'(IDX_PTEH))
                    && (req_wdata[ASID_W-1:0] != asid_q);
    end

    mxr_bank #(
        .DATA_W   (DATA_W),
        .ASID_W   (ASID_W),
        .EVT_W    (EVT_W),
        .ASSIST_W (ASSIST_W),
        .INV_BIT  (INV_BIT)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .idx     (idx),
        .wdata   (req_wdata),
        .rd_data (rd_data),
        .asid_q  (asid_q)
    );

    mxr_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .legal     (legal),
        .rd_data   (rd_data),
        .inval_req (inval_req),
        .flush_req (flush_req),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .tlb_inval (tlb_inval),
        .tlb_flush (tlb_flush)
    );
endmodule

// File: rtl/mxr_checker.sv
// Module: protocol checker for mmu_exc_regs, attached by bind.
// Relates the bus request to the response and the TLB pulses one cycle later.
module mxr_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int EVT_W   = 11,
    parameter int INV_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tlb_inval,
    input logic              tlb_flush
);
    AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval |-> $past(req_valid && req_write && req_size == 2'd2
                            && req_addr == ADDR_W'(0) && req_wdata[INV_BIT])); // R2
    AST_INVAL_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval |-> (rsp_valid && !rsp_err)); // R2
    AST_CTRL_INV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && $past(!req_write && req_addr == ADDR_W'(0)))
        |-> !rsp_rdata[INV_BIT]); // R3
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(req_valid && req_write && req_size == 2'd2
                            && req_addr == ADDR_W'(4))); // R4
    AST_EVT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!req_write && (req_addr == ADDR_W'(24)
                            || req_addr == ADDR_W'(28) || req_addr == ADDR_W'(32))))
        |-> ((rsp_rdata >> EVT_W) == '0)); // R6
    AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!tlb_inval && !tlb_flush && rsp_rdata == '0)); // R10
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11
endmodule

bind mmu_exc_regs mxr_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .EVT_W   (EVT_W),
    .INV_BIT (INV_BIT)
) u_mxr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .tlb_inval (tlb_inval),
    .tlb_flush (tlb_flush)
);

// File: tb/tb_mmu_exc_regs.sv
// Directed bench for mmu_exc_regs: one task per scenario.
module tb_mmu_exc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        tlb_inval;
    logic        tlb_flush;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Captured response of the last access
    logic        c_valid, c_err, c_inval, c_flush;
    logic [31:0] c_rdata;

    always #10 clk = ~clk;

    mmu_exc_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .tlb_inval (tlb_inval),
        .tlb_flush (tlb_flush)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge; capture the response one cycle later
    task automatic access(input bit wr, input logic [7:0] addr, input logic [1:0] sz,
                          input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_size = sz; req_wdata = data;
        @(negedge clk);
        c_valid = rsp_valid; c_err = rsp_err; c_rdata = rsp_rdata;
        c_inval = tlb_inval; c_flush = tlb_flush;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] addr, input logic [31:0] exp,
                             input string req);
        access(1'b0, addr, 2'd2, '0);
        check(c_valid && !c_err, {req, " read ok"}, {31'b0, c_err}, 32'h0);
        check(c_rdata == exp, req, c_rdata, exp);
    endtask

    task automatic t_reset();
        check(!tlb_inval && !tlb_flush, "R1 pulses idle",
              {30'b0, tlb_inval, tlb_flush}, 32'h0);
        for (int i = 0; i < 9; i++) rd_expect(8'(i * 4), 32'h0, "R1 reset value");
    endtask

    task automatic t_inval();
        access(1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF);
        check(c_valid && c_inval, "R2 inval pulse", {31'b0, c_inval}, 32'h1);
        @(negedge clk);
        check(!tlb_inval, "R2 pulse one cycle", {31'b0, tlb_inval}, 32'h0);
        check(!rsp_valid, "R11 no response when idle", {31'b0, rsp_valid}, 32'h0);
        rd_expect(8'h00, 32'hFFFF_FFFB, "R3 inval bit reads 0");
        access(1'b1, 8'h00, 2'd2, 32'h0000_0001);
        check(!c_inval, "R2 no pulse with bit clear", {31'b0, c_inval}, 32'h0);
        rd_expect(8'h00, 32'h0000_0001, "R3 other bits stored");
    endtask

    task automatic t_asid();
        access(1'b1, 8'h04, 2'd2, 32'h0000_0012);
        check(c_flush, "R4 flush on new asid", {31'b0, c_flush}, 32'h1);
        access(1'b1, 8'h04, 2'd2, 32'hABCD_0012);
        check(!c_flush, "R5 no flush same asid", {31'b0, c_flush}, 32'h0);
        rd_expect(8'h04, 32'hABCD_0012, "R5 upper bits stored");
        access(1'b1, 8'h04, 2'd2, 32'hABCD_0013);
        check(c_flush, "R4 flush on asid change", {31'b0, c_flush}, 32'h1);
    endtask

    task automatic t_masks();
        access(1'b1, 8'h18, 2'd2, 32'hFFFF_FFFF);
        rd_expect(8'h18, 32'hFFFF_FFFF & 32'h7FF, "R6 trap code masked");
        access(1'b1, 8'h1C, 2'd2, 32'h1234_5ABC);
        rd_expect(8'h1C, 32'h1234_5ABC & 32'h7FF, "R6 exc event masked");
        access(1'b1, 8'h20, 2'd2, 32'hF0F0_F3C5);
        rd_expect(8'h20, 32'hF0F0_F3C5 & 32'h7FF, "R6 int event masked");
        access(1'b1, 8'h0C, 2'd2, 32'hDEAD_BEEF);
        rd_expect(8'h0C, 32'h0000_000F, "R7 assist masked");
    endtask

    task automatic t_full();
        access(1'b1, 8'h08, 2'd2, 32'hA5A5_5A5A);
        access(1'b1, 8'h10, 2'd2, 32'h8000_0001);
        access(1'b1, 8'h14, 2'd2, 32'hFEDC_BA98);
        rd_expect(8'h08, 32'hA5A5_5A5A, "R8 entry low full");
        rd_expect(8'h10, 32'h8000_0001, "R8 table base full");
        rd_expect(8'h14, 32'hFEDC_BA98, "R8 exc addr full");
    endtask

    task automatic t_undecoded();
        access(1'b1, 8'h24, 2'd2, 32'h1111_1111);
        check(c_valid && c_err, "R9 err above map", {31'b0, c_err}, 32'h1);
        access(1'b1, 8'h09, 2'd2, 32'h2222_2222);
        check(c_err, "R9 err misaligned", {31'b0, c_err}, 32'h1);
        access(1'b0, 8'h24, 2'd2, '0);
        check(c_err && c_rdata == 32'h0, "R9 read err data 0", c_rdata, 32'h0);
        rd_expect(8'h08, 32'hA5A5_5A5A, "R9 entry low unchanged");
        rd_expect(8'h0C, 32'h0000_000F, "R9 assist unchanged");
    endtask

    task automatic t_width();
        access(1'b1, 8'h04, 2'd1, 32'h0000_0077);
        check(c_err && !c_flush, "R10 half write rejected",
              {30'b0, c_err, c_flush}, 32'h2);
        rd_expect(8'h04, 32'hABCD_0013, "R10 entry high unchanged");
        access(1'b1, 8'h00, 2'd0, 32'h0000_0004);
        check(c_err && !c_inval, "R10 byte write no pulse",
              {30'b0, c_err, c_inval}, 32'h2);
        access(1'b1, 8'h08, 2'd3, 32'h0);
        check(c_err, "R10 reserved width", {31'b0, c_err}, 32'h1);
        access(1'b0, 8'h08, 2'd1, '0);
        check(c_err && c_rdata == 32'h0, "R10 half read rejected", c_rdata, 32'h0);
        rd_expect(8'h08, 32'hA5A5_5A5A, "R10 entry low unchanged");
        rd_expect(8'h00, 32'h0000_0001, "R10 ctrl unchanged");
        access(1'b1, 8'h04, 2'd2, 32'h0000_0077);
        check(c_flush, "R4 flush uses stored asid", {31'b0, c_flush}, 32'h1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inval();
        t_asid();
        t_masks();
        t_full();
        t_undecoded();
        t_width();
        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
        finish_run();
    end
endmodule